// File: doc/BRIEF.md
# Test Stimulus Injection and Isolation Multiplexers

This block wraps a small processor core. It decides whether the core's inputs, and the pins the core would normally drive, come from the surrounding user logic or from a test source. When `test_mode` is low, every core input follows its user-side signal and every output pin follows its user-side signal. The wrapper is then transparent.

When `test_mode` is high, the wrapper takes over:
- A 16-bit stimulus register is parallel-loaded with a pattern. It then shifts that pattern out toward the core's serial stimulus input, most significant bit first.
- Two shared test pins are each steered to one of a pair of core inputs, chosen by a control bit:
  - One pin drives either timer input 2 or timer input 3.
  - The other pin drives either the ready input or the hold input.
  - The input that is not chosen is held at 0.
- The core clock and the core reset each pass through their own 2:1 multiplexer.
- The nine output pins show the core's observation outputs.

The stimulus register is sequenced by a three-state machine:
- **EMPTY** holds no pattern.
- **ARMED** holds a freshly loaded pattern that has not yet shifted.
- **SHIFT** is partway through the pattern.

Its transitions are:
- *load*: any state goes to ARMED when `load_en` is high.
- *first shift*: ARMED goes to SHIFT.
- *continue*: SHIFT stays in SHIFT.
- *drain*: ARMED or SHIFT goes to EMPTY on the shift that moves out the last pattern bit.
- *idle*: with neither load nor shift, the state holds.

The two steering bits sit in a small control register. It is written synchronously and cleared on reset.

Top module: `tap_wrapper`

## Requirements
- R1: After reset (`rst_n` low), both control bits are 0, the stimulus machine is EMPTY, `stim_valid` is 0, and the test stimulus bit is 0.
- R2: A cycle with `load_en` high captures `load_data`. From the next cycle on, `stim_valid` is 1 and the test stimulus bit equals `load_data[15]`.
- R3: Each cycle with `shift_en` high in ARMED or SHIFT presents the next lower pattern bit. After the k-th shift the test stimulus bit equals bit 15-k of the pattern. The 16th shift returns the machine to EMPTY, with `stim_valid` 0 and a stimulus bit of 0.
- R4: When `load_en` and `shift_en` are high in the same cycle, the load wins. The machine is ARMED with the new pattern and nothing is shifted.
- R5: `shift_en` while EMPTY has no effect: `stim_valid` and the stimulus bit stay 0.
- R6: A cycle with `ctl_we` high stores `ctl_wdata` into the control register. Bit 0 is the timer select: 0 selects timer 2 and 1 selects timer 3. Bit 1 is the ready/hold select: 0 selects ready and 1 selects hold. Without `ctl_we` the bits hold.
- R7: In test mode, `tp_timer` drives the timer input named by control bit 0, and the other timer input is 0.
- R8: In test mode, `tp_rdyhold` drives the input named by control bit 1 (ready or hold), and the other one is 0.
- R9: `core_clk` and `core_rst` equal `tp_clk` and `tp_rst` in test mode, and `usr_clk` and `usr_rst` otherwise.
- R10: `pad_out[i]`, for i = 0 to 8, equals `core_obs[i]` in test mode and `usr_pad[i]` otherwise.
- R11: In test mode, `core_stim` carries the stimulus register's most significant bit. Outside test mode, every core input equals its user-side input and the test pins have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the stimulus register and the control register |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | 1 selects test sources, 0 selects user sources |
| load_en | input | 1 | Parallel-load strobe for the stimulus register |
| load_data | input | 16 | Pattern to load |
| shift_en | input | 1 | Shift the stimulus register by one bit |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Bit 0 is the timer select, bit 1 is the ready/hold select |
| tp_timer | input | 1 | Shared test pin for the timer inputs |
| tp_rdyhold | input | 1 | Shared test pin for ready/hold |
| tp_clk | input | 1 | Test clock source |
| tp_rst | input | 1 | Test reset source |
| usr_clk | input | 1 | User clock source |
| usr_rst | input | 1 | User reset source |
| usr_tmr2 | input | 1 | User timer 2 input |
| usr_tmr3 | input | 1 | User timer 3 input |
| usr_rdy | input | 1 | User ready input |
| usr_hold | input | 1 | User hold input |
| usr_stim | input | 1 | User drive of the core stimulus input |
| usr_pad | input | 9 | User-side sources for the output pins |
| core_obs | input | 9 | Core-side sources for the output pins |
| core_clk | output | 1 | Clock to the core |
| core_rst | output | 1 | Reset to the core |
| core_tmr2 | output | 1 | Timer 2 input to the core |
| core_tmr3 | output | 1 | Timer 3 input to the core |
| core_rdy | output | 1 | Ready input to the core |
| core_hold | output | 1 | Hold input to the core |
| core_stim | output | 1 | Serial stimulus input to the core |
| stim_valid | output | 1 | Stimulus register holds unshifted pattern bits |
| pad_out | output | 9 | Output pins |

## Verification
The embedded assertions check the following on every cycle:
- the load, shift and drain steps of the stimulus machine;
- load priority over shift;
- the quiet EMPTY state;
- control-register write and hold;
- mutual exclusion of each steered pair in test mode.

The bench shows what no single-cycle property can. It walks complete patterns bit by bit to confirm the MSB-first order and the drain after sixteen shifts. It also sweeps every combination of control bits, mode, test pins and user inputs, comparing each multiplexer output with an arithmetic model.

// File: rtl/tap_pkg.sv
package tap_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2
    } shift_state_e;

    typedef struct packed {
        logic hold_sel;
        logic tmr_sel;
    } tap_ctl_t;
endpackage

// File: rtl/tap_stim_shifter.sv
module tap_stim_shifter
    import tap_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_data,
    input  logic         shift_en,
    output logic         stim_bit,
    output logic         stim_valid
);
    localparam int CW = $clog2(W + 1);

    shift_state_e  state_q, state_d;
    logic [W-1:0]  sreg_q, sreg_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            sreg_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            sreg_q  <= sreg_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        sreg_d  = sreg_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (load_en) begin
                    state_d = ST_ARMED;
                    sreg_d  = load_data;
                    cnt_d   = CW'(W);
                end
            end
            ST_ARMED, ST_SHIFT: begin
                if (load_en) begin
                    state_d = ST_ARMED;
                    sreg_d  = load_data;
                    cnt_d   = CW'(W);
                end else if (shift_en) begin
                    sreg_d  = sreg_q << 1;
                    cnt_d   = cnt_q - 1'b1;
                    state_d = (cnt_q == CW'(1)) ? ST_EMPTY : ST_SHIFT;
                end
            end
            default: begin
                state_d = ST_EMPTY;
                sreg_d  = '0;
                cnt_d   = '0;
            end
        endcase
    end

    assign stim_bit   = sreg_q[W-1];
    assign stim_valid = (state_q != ST_EMPTY);

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (stim_valid && sreg_q == $past(load_data)));

    p_load_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && shift_en) |=> (state_q == ST_ARMED && cnt_q == CW'(W)));

    p_shift_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && shift_en && state_q != ST_EMPTY) |=> (sreg_q == ($past(sreg_q) << 1)));

    p_live_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_EMPTY) |-> (cnt_q != '0));

    p_quiet_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY && !load_en) |=> (state_q == ST_EMPTY && sreg_q == '0));
endmodule

// File: rtl/tap_ctrl_reg.sv
module tap_ctrl_reg
    import tap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we,
    input  tap_ctl_t wdata,
    output tap_ctl_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (we) q <= wdata;
    end

    p_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(wdata)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/tap_iso_mux.sv
module tap_iso_mux
    import tap_pkg::*;
#(
    parameter int NPAD = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            test_mode,
    input  tap_ctl_t        ctl,
    input  logic            stim_bit,
    input  logic            tp_timer,
    input  logic            tp_rdyhold,
    input  logic            tp_clk,
    input  logic            tp_rst,
    input  logic            usr_clk,
    input  logic            usr_rst,
    input  logic            usr_tmr2,
    input  logic            usr_tmr3,
    input  logic            usr_rdy,
    input  logic            usr_hold,
    input  logic            usr_stim,
    input  logic [NPAD-1:0] usr_pad,
    input  logic [NPAD-1:0] core_obs,
    output logic            core_clk,
    output logic            core_rst,
    output logic            core_tmr2,
    output logic            core_tmr3,
    output logic            core_rdy,
    output logic            core_hold,
    output logic            core_stim,
    output logic [NPAD-1:0] pad_out
);
    // Dedicated 2:1 paths for clock and reset
    assign core_clk  = test_mode ? tp_clk : usr_clk;
    assign core_rst  = test_mode ? tp_rst : usr_rst;
    assign core_stim = test_mode ? stim_bit : usr_stim;

    // Shared-pin steering: the unselected member is parked at 0
    always_comb begin
        if (test_mode) begin
            core_tmr2 = ctl.tmr_sel  ? 1'b0     : tp_timer;
            core_tmr3 = ctl.tmr_sel  ? tp_timer : 1'b0;
            core_rdy  = ctl.hold_sel ? 1'b0       : tp_rdyhold;
            core_hold = ctl.hold_sel ? tp_rdyhold : 1'b0;
        end else begin
            core_tmr2 = usr_tmr2;
            core_tmr3 = usr_tmr3;
            core_rdy  = usr_rdy;
            core_hold = usr_hold;
        end
    end

    // Output-side isolation muxes
    for (genvar i = 0; i < NPAD; i++) begin : g_pad
        assign pad_out[i] = test_mode ? core_obs[i] : usr_pad[i];
    end

    p_tmr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> !(core_tmr2 && core_tmr3));

    p_rh_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> !(core_rdy && core_hold));
endmodule

// File: rtl/tap_wrapper.sv
module tap_wrapper
    import tap_pkg::*;
#(
    parameter int W    = 16,
    parameter int NPAD = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            test_mode,
    input  logic            load_en,
    input  logic [W-1:0]    load_data,
    input  logic            shift_en,
    input  logic            ctl_we,
    input  logic [1:0]      ctl_wdata,
    input  logic            tp_timer,
    input  logic            tp_rdyhold,
    input  logic            tp_clk,
    input  logic            tp_rst,
    input  logic            usr_clk,
    input  logic            usr_rst,
    input  logic            usr_tmr2,
    input  logic            usr_tmr3,
    input  logic            usr_rdy,
    input  logic            usr_hold,
    input  logic            usr_stim,
    input  logic [NPAD-1:0] usr_pad,
    input  logic [NPAD-1:0] core_obs,
    output logic            core_clk,
    output logic            core_rst,
    output logic            core_tmr2,
    output logic            core_tmr3,
    output logic            core_rdy,
    output logic            core_hold,
    output logic            core_stim,
    output logic            stim_valid,
    output logic [NPAD-1:0] pad_out
);
    tap_ctl_t ctl_q;
    tap_ctl_t ctl_w;
    logic     stim_bit;

    assign ctl_w.tmr_sel  = ctl_wdata[0];
    assign ctl_w.hold_sel = ctl_wdata[1];

    tap_ctrl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_w),
        .q     (ctl_q)
    );

    tap_stim_shifter #(.W(W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .load_data  (load_data),
        .shift_en   (shift_en),
        .stim_bit   (stim_bit),
        .stim_valid (stim_valid)
    );

    tap_iso_mux #(.NPAD(NPAD)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_mode  (test_mode),
        .ctl        (ctl_q),
        .stim_bit   (stim_bit),
        .tp_timer   (tp_timer),
        .tp_rdyhold (tp_rdyhold),
        .tp_clk     (tp_clk),
        .tp_rst     (tp_rst),
        .usr_clk    (usr_clk),
        .usr_rst    (usr_rst),
        .usr_tmr2   (usr_tmr2),
        .usr_tmr3   (usr_tmr3),
        .usr_rdy    (usr_rdy),
        .usr_hold   (usr_hold),
        .usr_stim   (usr_stim),
        .usr_pad    (usr_pad),
        .core_obs   (core_obs),
        .core_clk   (core_clk),
        .core_rst   (core_rst),
        .core_tmr2  (core_tmr2),
        .core_tmr3  (core_tmr3),
        .core_rdy   (core_rdy),
        .core_hold  (core_hold),
        .core_stim  (core_stim),
        .pad_out    (pad_out)
    );

    // R1: the reset value must be visible on the first enabled edge
    p_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!stim_valid && ctl_q == '0));
endmodule

// File: tb/tap_wrapper_bench.sv
module tap_wrapper_bench;
    localparam int PERIOD = 10;
    localparam int W      = 16;
    localparam int NPAD   = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_mode = 1'b0, load_en = 1'b0, shift_en = 1'b0, ctl_we = 1'b0;
    logic [W-1:0] load_data = '0;
    logic [1:0] ctl_wdata = '0;
    logic tp_timer = 0, tp_rdyhold = 0, tp_clk = 0, tp_rst = 0;
    logic usr_clk = 0, usr_rst = 0, usr_tmr2 = 0, usr_tmr3 = 0;
    logic usr_rdy = 0, usr_hold = 0, usr_stim = 0;
    logic [NPAD-1:0] usr_pad = '0, core_obs = '0;
    logic core_clk, core_rst, core_tmr2, core_tmr3, core_rdy, core_hold;
    logic core_stim, stim_valid;
    logic [NPAD-1:0] pad_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model of the stimulus register
    logic [W-1:0] m_reg = '0;
    int           m_cnt = 0;

    always #(PERIOD/2) clk = ~clk;

    tap_wrapper u_tap_wrapper (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .load_en(load_en),
        .load_data(load_data), .shift_en(shift_en), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .tp_timer(tp_timer), .tp_rdyhold(tp_rdyhold),
        .tp_clk(tp_clk), .tp_rst(tp_rst), .usr_clk(usr_clk), .usr_rst(usr_rst),
        .usr_tmr2(usr_tmr2), .usr_tmr3(usr_tmr3), .usr_rdy(usr_rdy),
        .usr_hold(usr_hold), .usr_stim(usr_stim), .usr_pad(usr_pad),
        .core_obs(core_obs), .core_clk(core_clk), .core_rst(core_rst),
        .core_tmr2(core_tmr2), .core_tmr3(core_tmr3), .core_rdy(core_rdy),
        .core_hold(core_hold), .core_stim(core_stim), .stim_valid(stim_valid),
        .pad_out(pad_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // one clock with the given strobes; model updated from requirements R2..R5
    task automatic op(input logic ld, input logic sh, input logic [W-1:0] pat);
        load_en = ld; shift_en = sh; load_data = pat;
        step();
        load_en = 0; shift_en = 0;
        if (ld) begin
            m_reg = pat; m_cnt = W;
        end else if (sh && m_cnt > 0) begin
            m_reg = m_reg << 1; m_cnt--;
        end
    endtask

    task automatic chk_stim(input string req);
        chk({req, " stim"},  {15'd0, core_stim},  {15'd0, m_reg[W-1]});
        chk({req, " valid"}, {15'd0, stim_valid}, {15'd0, (m_cnt > 0)});
    endtask

    task automatic write_ctl(input logic [1:0] v);
        ctl_wdata = v; ctl_we = 1;
        step();
        ctl_we = 0;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] pats [4];
        pats[0] = 16'hA5C3; pats[1] = 16'h8001; pats[2] = 16'hFFFF; pats[3] = 16'h0000;

        // R1: reset state
        test_mode = 1;
        repeat (3) step();
        chk("R1 valid",  {15'd0, stim_valid}, 16'd0);
        chk("R1 stim",   {15'd0, core_stim},  16'd0);
        rst_n = 1;
        step();
        tp_timer = 1; tp_rdyhold = 1; #1;
        chk("R1 tmr2 via ctl=0", {15'd0, core_tmr2}, 16'd1);
        chk("R1 rdy via ctl=0",  {15'd0, core_rdy},  16'd1);
        tp_timer = 0; tp_rdyhold = 0;

        // R5: shifting while empty
        op(0, 1, '0); chk_stim("R5");
        op(0, 1, '0); chk_stim("R5");

        // R2/R3: full patterns, MSB first, drain
        foreach (pats[p]) begin
            op(1, 0, pats[p]);
            chk_stim("R2");
            for (int k = 1; k <= W; k++) begin
                op(0, 1, '0);
                chk({"R3 bit"}, {15'd0, core_stim}, {15'd0, (k < W) ? pats[p][W-1-k] : 1'b0});
                chk_stim("R3");
            end
            op(0, 1, '0); chk_stim("R5 after drain");
        end

        // R4: load beats shift, mid-pattern and when empty
        op(1, 0, 16'h1234);
        op(0, 1, '0); op(0, 1, '0);
        op(1, 1, 16'hC001); chk_stim("R4");
        op(0, 1, '0); chk_stim("R4 next");
        for (int k = 0; k < W; k++) op(0, 1, '0);
        op(1, 1, 16'h8000); chk_stim("R4 from empty");
        for (int k = 0; k < W; k++) op(0, 1, '0);
        chk_stim("R3 drained");

        // R6..R11: exhaustive mux sweep per control value
        for (int c = 0; c < 4; c++) begin
            write_ctl(c[1:0]);
            // R6: hold without write
            step();
            for (int v = 0; v < 4096; v++) begin
                logic [11:0] b;
                logic e2, e3, er, eh;
                b = v[11:0];
                {test_mode, tp_timer, tp_rdyhold, tp_clk, tp_rst, usr_clk,
                 usr_rst, usr_tmr2, usr_tmr3, usr_rdy, usr_hold, usr_stim} = b;
                #1;
                e2 = test_mode ? (c[0] ? 1'b0 : tp_timer) : usr_tmr2;
                e3 = test_mode ? (c[0] ? tp_timer : 1'b0) : usr_tmr3;
                er = test_mode ? (c[1] ? 1'b0 : tp_rdyhold) : usr_rdy;
                eh = test_mode ? (c[1] ? tp_rdyhold : 1'b0) : usr_hold;
                chk("R7 R6 tmr",  {14'd0, core_tmr2, core_tmr3}, {14'd0, e2, e3});
                chk("R8 R6 rdyhold", {14'd0, core_rdy, core_hold}, {14'd0, er, eh});
                chk("R9 clk/rst", {14'd0, core_clk, core_rst},
                    {14'd0, test_mode ? tp_clk : usr_clk, test_mode ? tp_rst : usr_rst});
                chk("R11 stim", {15'd0, core_stim}, {15'd0, test_mode ? 1'b0 : usr_stim});
            end
        end

        // R10: output pins
        for (int m = 0; m < 2; m++) begin
            test_mode = m[0];
            for (int v = 0; v < 512; v++) begin
                usr_pad  = v[NPAD-1:0];
                core_obs = ~v[NPAD-1:0] ^ 9'h0A5;
                #1;
                chk("R10 pads", {7'd0, pad_out}, {7'd0, m[0] ? core_obs : usr_pad});
            end
        end

        // R11: normal mode ignores loaded pattern
        test_mode = 0; usr_stim = 0;
        op(1, 0, 16'hFFFF);
        chk("R11 user stim", {15'd0, core_stim}, 16'd0);
        test_mode = 1; #1;
        chk("R11 test stim", {15'd0, core_stim}, 16'd1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule